// File: doc/BRIEF.md
# Event-Selected Performance Counter Bank

This block holds a parameterised set of machine-level performance monitors. Each monitor pairs a 15-bit event selector with a counter of configurable width. The counters occupy monitor indices 3 to 31. Every clock cycle the core presents a vector of single-cycle event pulses. A monitor advances by one when at least one of its selected events is present. It does not advance while the core sleeps or while its inhibit bit is set.

Software reaches the bank through a simple CSR port: an enable, a write strobe, a 12-bit address, write data and a machine-mode flag. Read data and an access-violation flag are registered, so both appear one cycle after the access. Monitor slots above the configured count behave as silent zero registers. Selector and counter contents are not reset, and software must load them before use.

Top module: `perf_cnt_bank`

## Requirements
- R1: The selector of monitor index n (3..31) sits at CSR address 0x320+n. Event bits 0 and 2..14 are writable. Bit 1 and bits 31..15 always read as zero. A selector changes only on a machine-mode write to its own address.
- R2: The counter advances by exactly one in a cycle when the bitwise AND of its selector and the event vector is nonzero. It advances by one even when several selected events occur together. Otherwise it holds.
- R3: While the sleep input is high, no counter advances.
- R4: While bit n of the inhibit input is high, the counter of monitor index n does not advance. Other counters are not affected.
- R5: The counter is CNT_W bits wide and LSB-aligned. Its low word is at 0xB00+n and its high word is at 0xB80+n. Bits at or above CNT_W read as zero. Advancing from 2^CNT_W-1 gives zero.
- R6: A carry out of the low word reaches the high word in the same cycle.
- R7: A write to the low or high word of a counter wins over an advance in that same cycle. The written word takes the write data (masked to CNT_W), and the other word keeps its value.
- R8: Selector and counter addresses of indices at or above 3+NUM_CNT read as zero and ignore writes. A machine-mode access to any bank address never raises the violation flag.
- R9: An access to a bank address with the machine-mode flag low raises the violation flag in the next cycle. Such an access returns zero and changes nothing.
- R10: Read data is registered with one cycle of latency and is zero after a cycle without an access. While reset is asserted, the read data and the violation flag are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset of the read path |
| evt_i | input | 15 | One-cycle event pulses, bit positions as in R1 |
| sleep_i | input | 1 | Core is in sleep; freezes all counters |
| inhibit_i | input | 32 | Per-index counting inhibit, bit n for index n |
| csr_en_i | input | 1 | CSR access valid this cycle |
| csr_we_i | input | 1 | Access is a write |
| csr_m_i | input | 1 | Access comes from machine mode |
| csr_addr_i | input | 12 | CSR address |
| csr_wdata_i | input | 32 | CSR write data |
| csr_rdata_o | output | 32 | Registered read data |
| csr_err_o | output | 1 | Registered access-violation flag |

## Verification
The bench pushes a counter across the 32-bit word boundary and also through its top value. A design with a broken carry chain would leave the high word stale. A design that ignores the width mask would show ones above bit CNT_W or fail to wrap to zero. The bench sets several selected events in one cycle, which catches a design that adds the number of events instead of one. It writes a counter in the same cycle as an event, which catches a design where the increment overwrites the write. Sleep and inhibit cycles with events present expose a counter that keeps running. Writes to slots above the configured count, and accesses with the machine-mode flag low, expose a design that stores the data, returns stale values or flags the wrong case.

// File: rtl/pcb_pkg.sv
package pcb_pkg;
   localparam int EVT_W = 15;
   // bit 1 has no event source and is tied low
   localparam logic [EVT_W-1:0] EVT_IMPL_MASK = 15'h7FFD;
   localparam int FIRST_IDX = 3;
   localparam int SLOT_CNT  = 32;
   // address pages (addr[11:5]) of the three register groups
   localparam logic [6:0] PAGE_SEL = 7'h19;
   localparam logic [6:0] PAGE_LO  = 7'h58;
   localparam logic [6:0] PAGE_HI  = 7'h5C;

   typedef enum logic [1:0] {
      GRP_NONE = 2'd0,
      GRP_SEL  = 2'd1,
      GRP_LO   = 2'd2,
      GRP_HI   = 2'd3
   } csr_grp_e;
endpackage

// File: rtl/pcb_csr_dec.sv
module pcb_csr_dec
   import pcb_pkg::*;
(
   input  logic [11:0] addr_i,
   output csr_grp_e    grp_o,
   output logic [4:0]  idx_o,
   output logic        in_bank_o
);
   logic [6:0] page;
   logic       idx_ok;

   assign page   = addr_i[11:5];
   assign idx_o  = addr_i[4:0];
   assign idx_ok = (addr_i[4:0] >= 5'(FIRST_IDX));

   always_comb begin
      grp_o = GRP_NONE;
      if (idx_ok) begin
         case (page)
            PAGE_SEL: grp_o = GRP_SEL;
            PAGE_LO:  grp_o = GRP_LO;
            PAGE_HI:  grp_o = GRP_HI;
            default:  grp_o = GRP_NONE;
         endcase
      end
   end

   assign in_bank_o = (grp_o != GRP_NONE);
endmodule

// File: rtl/pcb_counter.sv
module pcb_counter
   import pcb_pkg::*;
#(
   parameter int CNT_W = 40
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [EVT_W-1:0] evt_i,
   input  logic             sleep_i,
   input  logic             inhibit_i,
   input  logic             sel_we_i,
   input  logic             lo_we_i,
   input  logic             hi_we_i,
   input  logic [31:0]      wdata_i,
   output logic [31:0]      sel_o,
   output logic [31:0]      lo_o,
   output logic [31:0]      hi_o
);
   logic [EVT_W-1:0] sel_q;

   always_ff @(posedge clk) begin
      if (sel_we_i) sel_q <= wdata_i[EVT_W-1:0] & EVT_IMPL_MASK;
   end

   assign sel_o = 32'(sel_q);

   AST_SEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !sel_we_i |=> $stable(sel_q)); // R1

   generate
      if (CNT_W == 0) begin : g_nocnt
         assign lo_o = '0;
         assign hi_o = '0;
         logic unused_cnt;
         assign unused_cnt = ^{evt_i, sleep_i, inhibit_i, lo_we_i, hi_we_i};
      end else begin : g_cnt
         localparam logic [31:0] LO_MASK =
            (CNT_W >= 32) ? 32'hFFFF_FFFF : ((32'd1 << CNT_W) - 32'd1);
         logic [CNT_W-1:0] cnt_q;
         logic [63:0]      cur64;
         logic [63:0]      nxt64;
         logic             adv;

         assign cur64 = 64'(cnt_q);
         assign adv   = (|(evt_i & sel_q)) && !sleep_i && !inhibit_i;

         always_comb begin
            nxt64 = cur64;
            if (lo_we_i)       nxt64[31:0]  = wdata_i;
            else if (hi_we_i)  nxt64[63:32] = wdata_i;
            else if (adv)      nxt64        = cur64 + 64'd1;
         end

         always_ff @(posedge clk) begin
            cnt_q <= nxt64[CNT_W-1:0];
         end

         assign lo_o = cur64[31:0];
         assign hi_o = cur64[63:32];

         AST_STEP_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
            !(lo_we_i || hi_we_i) |=> (cnt_q == $past(cnt_q)) || (cnt_q == $past(cnt_q) + 1'b1)); // R2
         AST_SLEEP_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
            (sleep_i && !lo_we_i && !hi_we_i) |=> $stable(cnt_q)); // R3
         AST_INHIBIT_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
            (inhibit_i && !lo_we_i && !hi_we_i) |=> $stable(cnt_q)); // R4
         AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
            lo_we_i |=> lo_o == ($past(wdata_i) & LO_MASK)); // R7
      end
   endgenerate
endmodule

// File: rtl/perf_cnt_bank.sv
module perf_cnt_bank
   import pcb_pkg::*;
#(
   parameter int NUM_CNT = 4,
   parameter int CNT_W   = 40
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [EVT_W-1:0] evt_i,
   input  logic             sleep_i,
   input  logic [31:0]      inhibit_i,
   input  logic             csr_en_i,
   input  logic             csr_we_i,
   input  logic             csr_m_i,
   input  logic [11:0]      csr_addr_i,
   input  logic [31:0]      csr_wdata_i,
   output logic [31:0]      csr_rdata_o,
   output logic             csr_err_o
);
   localparam int LAST_IDX = FIRST_IDX + NUM_CNT;

   generate
      if (NUM_CNT < 0 || NUM_CNT > SLOT_CNT - FIRST_IDX) begin : g_bad_num
         $error("NUM_CNT out of range 0..29");
      end
      if (CNT_W < 0 || CNT_W > 64) begin : g_bad_w
         $error("CNT_W out of range 0..64");
      end
   endgenerate

   csr_grp_e    grp;
   logic [4:0]  dec_idx;
   logic        in_bank;
   logic        wr_ok;
   logic [31:0] rd_sel [SLOT_CNT];
   logic [31:0] rd_lo  [SLOT_CNT];
   logic [31:0] rd_hi  [SLOT_CNT];
   logic [31:0] mux_rd;
   logic [31:0] rdata_q;
   logic        err_q;
   logic        unused_inh;

   assign unused_inh = ^inhibit_i[FIRST_IDX-1:0];

   pcb_csr_dec u_dec (
      .addr_i    (csr_addr_i),
      .grp_o     (grp),
      .idx_o     (dec_idx),
      .in_bank_o (in_bank)
   );

   assign wr_ok = csr_en_i && csr_we_i && csr_m_i;

   generate
      for (genvar n = 0; n < SLOT_CNT; n++) begin : g_slot
         if (n >= FIRST_IDX && n < LAST_IDX) begin : g_live
            logic hit;
            assign hit = wr_ok && (dec_idx == 5'(n));
            pcb_counter #(.CNT_W(CNT_W)) u_cnt (
               .clk       (clk),
               .rst_n     (rst_n),
               .evt_i     (evt_i),
               .sleep_i   (sleep_i),
               .inhibit_i (inhibit_i[n]),
               .sel_we_i  (hit && grp == GRP_SEL),
               .lo_we_i   (hit && grp == GRP_LO),
               .hi_we_i   (hit && grp == GRP_HI),
               .wdata_i   (csr_wdata_i),
               .sel_o     (rd_sel[n]),
               .lo_o      (rd_lo[n]),
               .hi_o      (rd_hi[n])
            );
         end else begin : g_zero
            assign rd_sel[n] = '0;
            assign rd_lo[n]  = '0;
            assign rd_hi[n]  = '0;
         end
      end
   endgenerate

   always_comb begin
      case (grp)
         GRP_SEL: mux_rd = rd_sel[dec_idx];
         GRP_LO:  mux_rd = rd_lo[dec_idx];
         GRP_HI:  mux_rd = rd_hi[dec_idx];
         default: mux_rd = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdata_q <= '0;
         err_q   <= 1'b0;
      end else begin
         rdata_q <= (csr_en_i && csr_m_i) ? mux_rd : '0;
         err_q   <= csr_en_i && in_bank && !csr_m_i;
      end
   end

   assign csr_rdata_o = rdata_q;
   assign csr_err_o   = err_q;

   AST_UNPRIV_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      (csr_en_i && !csr_m_i && in_bank) |=> csr_err_o); // R9
   AST_UNPRIV_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (csr_en_i && !csr_m_i) |=> csr_rdata_o == 32'd0); // R9
   AST_PRIV_NO_ERR: assert property (@(posedge clk) disable iff (!rst_n)
      (csr_en_i && csr_m_i) |=> !csr_err_o); // R8
   AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !csr_en_i |=> (csr_rdata_o == 32'd0) && !csr_err_o); // R10
endmodule

// File: tb/perf_cnt_bank_tb.sv
`timescale 1ns/1ps
module perf_cnt_bank_tb;
   localparam int NUM = 4;
   localparam int CW  = 40;
   localparam logic [63:0] CMASK = (CW == 64) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'd1 << CW) - 64'd1);

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [14:0] evt = '0;
   logic        sleep = 1'b0;
   logic [31:0] inh = '0;
   logic        en = 1'b0, we = 1'b0, m = 1'b1;
   logic [11:0] addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic        err;

   int nchk = 0;
   int nfail = 0;
   bit done = 0;

   logic [14:0] m_sel [NUM];
   logic [63:0] m_cnt [NUM];

   always #2.5 clk = ~clk;

   perf_cnt_bank #(.NUM_CNT(NUM), .CNT_W(CW)) u_dut (
      .clk(clk), .rst_n(rst_n), .evt_i(evt), .sleep_i(sleep), .inhibit_i(inh),
      .csr_en_i(en), .csr_we_i(we), .csr_m_i(m), .csr_addr_i(addr),
      .csr_wdata_i(wdata), .csr_rdata_o(rdata), .csr_err_o(err)
   );

   // group: 1 selector, 2 low, 3 high, 0 none
   function automatic int grp_of(logic [11:0] a);
      if (a[4:0] < 5'd3) return 0;
      case (a[11:5])
         7'h19: return 1;
         7'h58: return 2;
         7'h5C: return 3;
         default: return 0;
      endcase
   endfunction

   function automatic logic [31:0] exp_rd();
      int g = grp_of(addr);
      int k = int'(addr[4:0]) - 3;
      if (!en || !m || g == 0 || k >= NUM) return 32'd0;
      if (g == 1) return 32'(m_sel[k]);
      if (g == 2) return m_cnt[k][31:0];
      return m_cnt[k][63:32];
   endfunction

   function automatic logic exp_err();
      return en && !m && (grp_of(addr) != 0);
   endfunction

   task automatic model_step();
      int g = grp_of(addr);
      for (int k = 0; k < NUM; k++) begin
         logic hit = en && we && m && (int'(addr[4:0]) == k + 3);
         logic adv = (|(evt & m_sel[k])) && !sleep && !inh[k+3];
         if (hit && g == 2)      m_cnt[k] = {m_cnt[k][63:32], wdata} & CMASK;
         else if (hit && g == 3) m_cnt[k] = {wdata, m_cnt[k][31:0]} & CMASK;
         else if (adv)           m_cnt[k] = (m_cnt[k] + 64'd1) & CMASK;
         if (hit && g == 1)      m_sel[k] = wdata[14:0] & 15'h7FFD;
      end
   endtask

   task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
      nchk++;
      if (got !== exp) begin
         nfail++;
         $display("FAIL %s got %h expected %h", tag, got, exp);
      end
   endtask

   // one cycle: inputs set now (after a falling edge), result checked at next falling edge
   task automatic cyc(string tag, logic e, logic w, logic mm, logic [11:0] a,
                      logic [31:0] d, logic [14:0] ev, logic sl, logic [31:0] ih);
      logic [31:0] er;
      logic        ee;
      en = e; we = w; m = mm; addr = a; wdata = d; evt = ev; sleep = sl; inh = ih;
      er = exp_rd();
      ee = exp_err();
      @(posedge clk);
      model_step();
      @(negedge clk);
      check(tag, rdata, er);
      check(tag, 32'(err), 32'(ee));
   endtask

   task automatic wr(string tag, logic [11:0] a, logic [31:0] d);
      cyc(tag, 1'b1, 1'b1, 1'b1, a, d, 15'd0, 1'b0, 32'd0);
   endtask

   task automatic rd(string tag, logic [11:0] a);
      cyc(tag, 1'b1, 1'b0, 1'b1, a, 32'd0, 15'd0, 1'b0, 32'd0);
   endtask

   task automatic ev(string tag, logic [14:0] e, logic sl, logic [31:0] ih);
      cyc(tag, 1'b0, 1'b0, 1'b1, 12'h000, 32'd0, e, sl, ih);
   endtask

   initial begin
      #(5.0 * 200000);
      if (!done) begin
         nfail++;
         nchk++;
         $display("FAIL watchdog expired");
         $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (4) @(negedge clk);
      check("R10 reset rdata", rdata, 32'd0);
      check("R10 reset err", 32'(err), 32'd0);
      rst_n = 1'b1;
      @(negedge clk);

      for (int k = 0; k < NUM; k++) begin
         wr("R1 init", 12'h320 + 12'(k + 3), 32'd0);
         wr("R5 init", 12'hB00 + 12'(k + 3), 32'd0);
         wr("R5 init", 12'hB80 + 12'(k + 3), 32'd0);
      end

      // R1: bit 1 and upper bits never stick
      wr("R1 sel write", 12'h323, 32'hFFFF_FFFF);
      rd("R1 sel readback", 12'h323);
      check("R1 literal", m_sel[0], 15'h7FFD);
      // R2: several events in one cycle add one
      ev("R2 multi event", 15'h1FFD, 1'b0, 32'd0);
      rd("R2 count one", 12'hB03);
      check("R2 literal", m_cnt[0][31:0], 32'd1);
      // R3: sleep freezes
      ev("R3 sleep", 15'h7FFF, 1'b1, 32'd0);
      ev("R3 sleep", 15'h7FFF, 1'b1, 32'd0);
      rd("R3 frozen", 12'hB03);
      // R4: inhibit on index 3 only
      wr("R4 sel idx4", 12'h324, 32'h1);
      ev("R4 inhibit", 15'h1, 1'b0, 32'h8);
      rd("R4 idx3 frozen", 12'hB03);
      rd("R4 idx4 counts", 12'hB04);
      // R6: carry into high word
      wr("R6 sel", 12'h325, 32'h4);
      wr("R6 lo", 12'hB05, 32'hFFFF_FFFF);
      ev("R6 event", 15'h4, 1'b0, 32'd0);
      rd("R6 hi", 12'hB85);
      rd("R6 lo", 12'hB05);
      check("R6 literal", m_cnt[2][63:32], 32'd1);
      // R5: width mask and wrap
      wr("R5 hi all ones", 12'hB85, 32'hFFFF_FFFF);
      rd("R5 hi masked", 12'hB85);
      wr("R5 lo all ones", 12'hB05, 32'hFFFF_FFFF);
      ev("R5 wrap", 15'h4, 1'b0, 32'd0);
      rd("R5 wrap lo", 12'hB05);
      rd("R5 wrap hi", 12'hB85);
      check("R5 literal", m_cnt[2][31:0], 32'd0);
      // R7: write wins over an event
      wr("R7 sel", 12'h326, 32'h1);
      cyc("R7 write+event", 1'b1, 1'b1, 1'b1, 12'hB06, 32'h100, 15'h1, 1'b0, 32'd0);
      rd("R7 written", 12'hB06);
      check("R7 literal", m_cnt[3][31:0], 32'h100);
      // R8: unimplemented slots
      wr("R8 unimpl sel", 12'h327, 32'h1);
      wr("R8 unimpl lo", 12'hB07, 32'h55);
      rd("R8 unimpl lo", 12'hB07);
      rd("R8 unimpl sel", 12'h33F);
      rd("R8 outside bank", 12'hB00);
      // R9: user access
      cyc("R9 user read", 1'b1, 1'b0, 1'b0, 12'hB03, 32'd0, 15'd0, 1'b0, 32'd0);
      cyc("R9 user write", 1'b1, 1'b1, 1'b0, 12'hB03, 32'hDEAD, 15'd0, 1'b0, 32'd0);
      rd("R9 unchanged", 12'hB03);
      // R10: idle returns zero
      ev("R10 idle", 15'd0, 1'b0, 32'd0);

      for (int i = 0; i < 4000; i++) begin
         int kind = int'($urandom % 4);
         int idx = (($urandom % 8) == 0) ? int'($urandom % 32) : 3 + int'($urandom % (NUM + 2));
         logic [11:0] a;
         logic mm = (($urandom % 8) != 0);
         logic w = (($urandom % 3) == 0);
         string tag;
         case (kind)
            0: a = 12'h320 + 12'(idx);
            1: a = 12'hB00 + 12'(idx);
            2: a = 12'hB80 + 12'(idx);
            default: a = 12'(idx);
         endcase
         if (!mm) tag = "R9 random";
         else if (grp_of(a) != 0 && idx - 3 >= NUM) tag = "R8 random";
         else if (kind == 0) tag = "R1 random";
         else tag = "R2 random";
         cyc(tag, ($urandom % 4) != 0, w, mm, a,
             (($urandom % 4) == 0) ? 32'hFFFF_FFF0 + ($urandom % 16) : $urandom,
             15'($urandom) & 15'($urandom) & 15'($urandom),
             ($urandom % 6) == 0, $urandom & $urandom & $urandom);
      end

      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end
endmodule